// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block moves bytes over a two-wire synchronous link in which the local side always supplies the clock. One pin carries the shift clock. The other pin carries data in both directions. The block drives the data pin while it transmits and releases it while it receives, so that a slave device can drive it. Bits travel least significant first. The data pin changes on the falling edge of the shift clock, and received data is sampled on the rising edge.

The transmit side has two stages: a holding buffer and a shift register. Software can queue the next byte while the current one is still shifting out. The second byte then follows the first with no idle gap. The receive side runs one byte at a time. Writing the receive-enable bit arms it, and the bit clears itself once eight bits have arrived.

The shift clock comes from a pre-divider followed by a reload timer. Each timer expiry produces one half period of the shift clock. A run bit gates all activity.

Top module: `sync_shift_channel`

## Requirements
- R1: After reset, `sclk_o` and `data_o` are high, `data_oe` is high, `rx_en` is low, and every interrupt output is low.
- R2: If `run_en` is high and `rx_en` is low, a byte written while the shifter is idle moves into the shift register within 4 clock cycles. That move frees the buffer and produces a one-cycle pulse on `tx_empty_irq`.
- R3: While `run_en` is low or `rx_en` is high, a written transmit byte stays buffered and no pulse appears on `tx_empty_irq`. Transmission begins once both conditions allow it.
- R4: A frame is 8 bits, sent least significant bit first. `data_o` changes at each falling edge of `sclk_o`. One shift-clock period lasts 2*PREDIV*(reload+1) system clock cycles.
- R5: A byte buffered during a transmission follows the current frame with no gap. At the rising edge that ends the first frame, `tx_done_irq` stays low and `tx_empty_irq` pulses.
- R6: At the rising edge that ends the last pending frame, `sclk_o` and `data_o` are high, `tx_done_irq` pulses for one cycle, and the shift clock stops.
- R7: A pulse on `rx_arm` sets `rx_en`. While `run_en` is high, the block then releases the data pin (`data_oe` low) and samples `data_i` on 8 rising edges of `sclk_o`, least significant bit first.
- R8: At the 8th rising edge of a reception, `rx_data` takes the received byte, `rx_irq` becomes high and stays high, `rx_en` clears itself, and `data_oe` returns high.
- R9: A pulse on `rx_rd` clears both `rx_irq` and `rx_ovr`.
- R10: If a reception completes while `rx_irq` is still set, `rx_ovr` becomes high and `rx_data` is overwritten with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run bit; gates the baud timer and frame starts |
| reload | input | RW | Reload value of the baud timer |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | DW | Byte to transmit |
| rx_arm | input | 1 | Strobe that sets the receive-enable bit |
| rx_rd | input | 1 | Read strobe that acknowledges a received byte |
| rx_en | output | 1 | Receive-enable bit; clears itself after a byte |
| rx_data | output | DW | Receive buffer |
| sclk_o | output | 1 | Shift clock pin, high when idle |
| data_o | output | 1 | Data pin output value |
| data_oe | output | 1 | Data pin output enable; low while receiving |
| data_i | input | 1 | Data pin input value |
| tx_empty_irq | output | 1 | One-cycle pulse when the buffer moves to the shifter |
| tx_done_irq | output | 1 | One-cycle pulse when the shifter stops after a frame |
| rx_irq | output | 1 | Sticky flag: a received byte is waiting |
| rx_ovr | output | 1 | Sticky flag: a received byte overwrote an unread one |

## Verification
The bench queues a second byte during a transmission and checks that the frame boundary produces a buffer-empty pulse and no done pulse. A design that stops between the two frames, or that raises the done flag too early, fails this check. The bench also arms a reception while a transmit byte waits in the buffer. A design that lets the transmitter override the armed receiver would drive the data pin during reception and emit the wrong frames. The bench then confirms that the receive-enable bit clears at the eighth bit. If it did not, the block would start an endless second reception and the queued byte would never go out. Finally, the bench counts shift-clock periods and checks the bit order, which catches a wrong reload count or a wrong shift direction.

// File: rtl/ssc_pkg.sv
// Package: shared types for the synchronous serial shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package ssc_pkg;
    // Shifter operating state
    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_TX   = 2'd1,
        SH_RX   = 2'd2
    } sh_state_e;
endpackage

// File: rtl/ssc_baud.sv
// Module: ssc_baud
// Emits a one-cycle tick every PREDIV*(reload+1) system clocks while en is high.
// Assumes: reload is stable while en is high; deasserting en restarts the count.
module ssc_baud #(
    parameter int PREDIV = 2,
    parameter int RW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    localparam int PW = (PREDIV > 1) ? $clog2(PREDIV) : 1;

    logic [PW-1:0] pre_q;
    logic [RW-1:0] tmr_q;
    logic          pre_end;

    assign pre_end = (pre_q == PW'(PREDIV - 1));
    assign tick    = en && pre_end && (tmr_q == '0);

    // Pre-divider and reload down-counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q <= '0;
            tmr_q <= reload;
        end else if (pre_end) begin
            pre_q <= '0;
            tmr_q <= (tmr_q == '0) ? reload : tmr_q - 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssc_shifter.sv
// Module: ssc_shifter
// Frame engine: drives the shift clock and the data pin, shifts LSB first.
// Each tick is one half period; data changes on falling, samples on rising.
// Assumes: start requests are evaluated only while idle; take/rx_done are
// combinational so the top updates its buffers in the same cycle.
module ssc_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          tick,
    input  logic          rx_en,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_buf,
    input  logic          data_i,
    output logic          busy,
    output logic          take,
    output logic          tx_done,
    output logic          rx_done,
    output logic [DW-1:0] rx_byte,
    output logic          sclk_o,
    output logic          data_o,
    output logic          data_oe
);
    import ssc_pkg::*;
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    sh_state_e     state_q;
    logic          phase_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] sh_q;
    logic          go_tx, go_rx, bit_end, load_next;

    assign busy      = (state_q != SH_IDLE);
    assign go_tx     = !busy && run_en && !rx_en && tx_full;
    assign go_rx     = !busy && run_en && rx_en;
    assign bit_end   = tick && phase_q && (cnt_q == LAST);
    assign load_next = (state_q == SH_TX) && bit_end && tx_full && !rx_en;
    assign take      = go_tx || load_next;
    assign tx_done   = (state_q == SH_TX) && bit_end && !load_next;
    assign rx_done   = (state_q == SH_RX) && bit_end;
    assign rx_byte   = {data_i, sh_q[DW-1:1]};

    // Frame sequencing, pin drive and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            phase_q <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
            sclk_o  <= 1'b1;
            data_o  <= 1'b1;
            data_oe <= 1'b1;
        end else if (go_tx) begin
            state_q <= SH_TX;
            sh_q    <= tx_buf;
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (go_rx) begin
            state_q <= SH_RX;
            data_oe <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else if (busy && tick) begin
            if (!phase_q) begin
                sclk_o  <= 1'b0;
                phase_q <= 1'b1;
                if (state_q == SH_TX) data_o <= sh_q[0];
            end else begin
                sclk_o  <= 1'b1;
                phase_q <= 1'b0;
                cnt_q   <= cnt_q + 1'b1;
                if (state_q == SH_TX) sh_q <= sh_q >> 1;
                else                  sh_q <= rx_byte;
                if (cnt_q == LAST) begin
                    data_o <= 1'b1;
                    cnt_q  <= '0;
                    if (load_next) begin
                        sh_q <= tx_buf;
                    end else begin
                        state_q <= SH_IDLE;
                        data_oe <= 1'b1;
                    end
                end
            end
        end
    end

    // R6
    // idle_pins_high_chk: an idle shifter leaves the clock pin high
    idle_pins_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE) |-> sclk_o);

    // R7
    // rx_released_chk: the data pin is never driven during a reception
    rx_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_RX) |-> !data_oe);
endmodule

// File: rtl/sync_shift_channel.sv
// Module: sync_shift_channel
// Top: transmit holding buffer, receive buffer, enable bit and interrupt flags
// wrapped around the baud generator and the frame engine.
// Assumes: strobes are single-cycle and synchronous to clk.
module sync_shift_channel #(
    parameter int DW     = 8,
    parameter int RW     = 8,
    parameter int PREDIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [RW-1:0] reload,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          rx_arm,
    input  logic          rx_rd,
    output logic          rx_en,
    output logic [DW-1:0] rx_data,
    output logic          sclk_o,
    output logic          data_o,
    output logic          data_oe,
    input  logic          data_i,
    output logic          tx_empty_irq,
    output logic          tx_done_irq,
    output logic          rx_irq,
    output logic          rx_ovr
);
    logic          tick, busy, take, tx_done, rx_done;
    logic [DW-1:0] rx_byte;
    logic [DW-1:0] tx_buf_q;
    logic          tx_full_q;

    ssc_baud #(.PREDIV(PREDIV), .RW(RW)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(run_en && busy), .reload(reload), .tick(tick)
    );

    ssc_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .rx_en(rx_en),
        .tx_full(tx_full_q), .tx_buf(tx_buf_q), .data_i(data_i), .busy(busy),
        .take(take), .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte),
        .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe)
    );

    // Transmit holding buffer: a write wins over a same-cycle hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q  <= '0;
            tx_full_q <= 1'b0;
        end else if (tx_wr) begin
            tx_buf_q  <= tx_wdata;
            tx_full_q <= 1'b1;
        end else if (take) begin
            tx_full_q <= 1'b0;
        end
    end

    // Transmit interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty_irq <= 1'b0;
            tx_done_irq  <= 1'b0;
        end else begin
            tx_empty_irq <= take;
            tx_done_irq  <= tx_done;
        end
    end

    // Receive-enable bit: set by arm, cleared by frame completion
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_en <= 1'b0;
        else if (rx_done) rx_en <= 1'b0;
        else if (rx_arm)  rx_en <= 1'b1;
    end

    // Receive buffer, sticky receive flag and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_irq  <= 1'b0;
            rx_ovr  <= 1'b0;
        end else if (rx_done) begin
            rx_data <= rx_byte;
            rx_irq  <= 1'b1;
            if (rx_irq && !rx_rd) rx_ovr <= 1'b1;
        end else if (rx_rd) begin
            rx_irq <= 1'b0;
            rx_ovr <= 1'b0;
        end
    end

    // R2
    // empty_pulse_chk: every hand-off to the shifter is announced next cycle
    empty_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_empty_irq);

    // R3
    // rx_blocks_tx_chk: no hand-off while reception is armed
    rx_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> !take);

    // R8
    // rx_en_clear_chk: receive-enable drops after a completed byte
    rx_en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (!rx_en && rx_irq));

    // R10
    // overrun_set_chk: an unread byte being overwritten raises overrun
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_irq && !rx_rd) |=> rx_ovr);
endmodule

// File: tb/sync_shift_channel_test.sv
// Bench: directed scenarios, a slave model driven from tasks on the two pins.
module sync_shift_channel_test;
    localparam int DW = 8, RW = 8, PREDIV = 2;
    localparam logic [RW-1:0] RELOAD = 8'd2;
    localparam int SCLK_NS = 2 * PREDIV * (RELOAD + 1) * 10;

    logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0;
    logic [RW-1:0] reload = RELOAD;
    logic tx_wr = 1'b0, rx_arm = 1'b0, rx_rd = 1'b0, data_i = 1'b1;
    logic [DW-1:0] tx_wdata = '0;
    logic rx_en, sclk_o, data_o, data_oe, tx_empty_irq, tx_done_irq, rx_irq, rx_ovr;
    logic [DW-1:0] rx_data;
    int checks = 0, errors = 0;

    sync_shift_channel #(.DW(DW), .RW(RW), .PREDIV(PREDIV)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .reload(reload), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .rx_arm(rx_arm), .rx_rd(rx_rd), .rx_en(rx_en),
        .rx_data(rx_data), .sclk_o(sclk_o), .data_o(data_o), .data_oe(data_oe),
        .data_i(data_i), .tx_empty_irq(tx_empty_irq), .tx_done_irq(tx_done_irq),
        .rx_irq(rx_irq), .rx_ovr(rx_ovr)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_tx(input logic [DW-1:0] b);
        @(negedge clk); tx_wdata = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); rx_arm = 1'b1;
        @(negedge clk); rx_arm = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // Capture one frame from the data pin right after each falling edge
    task automatic grab(output logic [DW-1:0] b, output time period);
        time t0 = 0;
        for (int i = 0; i < DW; i++) begin
            @(negedge sclk_o);
            if (i == 1) period = $time - t0;
            t0 = $time;
            #1 b[i] = data_o;
        end
    endtask

    // Slave drives one byte, LSB first, after each falling edge
    task automatic feed(input logic [DW-1:0] b);
        for (int i = 0; i < DW; i++) begin
            @(negedge sclk_o); #1 data_i = b[i];
            check("R7 data pin released", data_oe, 1'b0);
        end
        @(posedge sclk_o); #1;
    endtask

    task automatic t_reset();
        check("R1 sclk", sclk_o, 1); check("R1 data", data_o, 1);
        check("R1 oe", data_oe, 1); check("R1 rx_en", rx_en, 0);
        check("R1 irqs", {tx_empty_irq, tx_done_irq, rx_irq, rx_ovr}, 0);
    endtask

    // R2 R4 R5 R6: buffered back-to-back transmit
    task automatic t_tx_pair();
        logic [DW-1:0] got; time per; int seen = 0;
        run_en = 1'b1;
        write_tx(8'hA5);
        for (int c = 0; c < 4; c++) begin
            if (tx_empty_irq) seen = 1;
            @(negedge clk);
        end
        check("R2 empty pulse within 4 cycles", seen, 1);
        write_tx(8'h3C);
        grab(got, per);
        check("R4 first byte LSB first", got, 8'hA5);
        check("R4 shift clock period", per, SCLK_NS);
        @(posedge sclk_o); #1;
        check("R5 no done between frames", tx_done_irq, 0);
        check("R5 empty pulse at frame boundary", tx_empty_irq, 1);
        grab(got, per);
        check("R5 second byte", got, 8'h3C);
        @(posedge sclk_o); #1;
        check("R6 done pulse", tx_done_irq, 1);
        check("R6 pins high", {sclk_o, data_o}, 2'b11);
        @(negedge clk); @(negedge clk);
        check("R6 done one cycle", tx_done_irq, 0);
        repeat (30) @(negedge clk);
        check("R6 clock stopped", sclk_o, 1);
    endtask

    // R3: run bit gates the start
    task automatic t_run_gate();
        logic [DW-1:0] got; time per; int seen = 0;
        run_en = 1'b0;
        write_tx(8'h81);
        for (int c = 0; c < 20; c++) begin
            if (tx_empty_irq || !sclk_o) seen = 1;
            @(negedge clk);
        end
        check("R3 held while run low", seen, 0);
        run_en = 1'b1;
        grab(got, per);
        check("R3 starts after run set", got, 8'h81);
        @(posedge sclk_o); #1;
        check("R6 done after gated frame", tx_done_irq, 1);
    endtask

    // R3 R7 R8 R9 R10: receive, armed receive blocks a buffered transmit
    task automatic t_rx();
        logic [DW-1:0] got; time per; int seen = 0;
        pulse_arm();
        check("R7 rx_en set", rx_en, 1);
        write_tx(8'h5A);
        fork
            feed(8'hC3);
            begin
                for (int c = 0; c < 100; c++) begin
                    if (tx_empty_irq) seen = 1;
                    @(negedge clk);
                end
            end
        join_any
        check("R8 rx_data", rx_data, 8'hC3);
        check("R8 rx_irq", rx_irq, 1);
        check("R8 rx_en cleared", rx_en, 0);
        check("R8 oe back", data_oe, 1);
        check("R3 no transmit during armed receive", seen, 0);
        grab(got, per);
        check("R3 buffered byte after receive", got, 8'h5A);
        @(posedge sclk_o); #1;
        pulse_arm();
        feed(8'h96);
        check("R10 overrun", rx_ovr, 1);
        check("R10 overwritten", rx_data, 8'h96);
        pulse_rd();
        check("R9 rx_irq cleared", rx_irq, 0);
        check("R9 overrun cleared", rx_ovr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_pair();
        t_run_gate();
        t_rx();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule